// File: doc/BRIEF.md
# Cascadable Base-4 Word Shifter

This block moves the digits of a four-digit base-4 word by zero to three digit positions in a single combinational pass. Each digit takes two bits. A two-bit mode input picks one of four operations: shift toward the most significant end, shift toward the least significant end, rotate right, or rotate left. A single base-4 digit gives the distance. A left shift multiplies the word by 4^k. A right shift divides it by 4^k.

For the two plain shifts, the block has three outgoing neighbour lanes and three incoming neighbour lanes. The outgoing lanes carry the digits that leave the word. The incoming lanes supply the digits that fill the vacated positions. With these lanes, several instances wired in a row act as one longer word. At the outer edge of such a chain, the incoming lanes are tied to zero. The rotate modes recirculate the four digits inside the word. In those modes the neighbour lanes play no part.

Top module: `quad_word_shifter`

## Requirements
- R1: With mode 2'b00 (left) and the incoming lanes at zero, the word output holds (W·4^k) mod 256. The outgoing lanes hold floor(W·4^k / 256), with lane 0 in bits [1:0]. Here W is the 8-bit word, with digit i in bits [2i+1:2i], and k is the distance input.
- R2: In left mode, every output digit i with i < k takes incoming lane i.
- R3: In left mode with k = 0, the outgoing lanes are zero and the word output equals the word input.
- R4: With mode 2'b01 (right) and the incoming lanes at zero, the word output holds floor(W / 4^k). The outgoing lanes hold (W mod 4^k) · 4^(3−k), so the digits that leave sit in the top k lanes.
- R5: In right mode, every output digit i with i ≥ 4−k takes incoming lane i−1.
- R6: Mode 2'b10 rotates the word right by k digits, so output digit i is input digit (i+k) mod 4. Mode 2'b11 rotates left, so output digit i is input digit (i−k) mod 4.
- R7: In both rotate modes the outgoing lanes are zero and the incoming lanes have no effect on any output.
- R8: Two instances in a row form an 8-digit shifter. In left mode, the outgoing lanes of the lower instance drive the incoming lanes of the upper one. In right mode, the outgoing lanes of the upper instance drive the incoming lanes of the lower one. In both cases the concatenated words equal the 16-bit value shifted by 2k bits, truncated to 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| word_i | input | 8 | Word to move; digit i in bits [2i+1:2i] |
| dist_i | input | 2 | Distance in digits, 0 to 3 |
| mode_i | input | 2 | 00 left, 01 right, 10 rotate right, 11 rotate left |
| lane_in_i | input | 6 | Three digits from the neighbour, lane j in bits [2j+1:2j] |
| word_o | output | 8 | Moved word |
| lane_out_o | output | 6 | Three digits sent to the neighbour |

## Verification
In one evaluation, a plain shift both pushes digits out on the outgoing lanes and pulls neighbour digits in at the opposite end. A wrong lane order or a wrong fill boundary only shows when both happen together. The bench provokes this by driving random words and random nonzero incoming lanes at every distance, in left and right mode. It compares the word output and the lanes against arithmetic references built from multiplication, division and masking. The chained pairs then confirm that the digits one instance emits are the ones its neighbour takes in.

// File: rtl/qws_pkg.sv
package qws_pkg;
    typedef enum logic [1:0] {
        MODE_LEFT  = 2'b00,
        MODE_RIGHT = 2'b01,
        MODE_ROTR  = 2'b10,
        MODE_ROTL  = 2'b11
    } qws_mode_e;
endpackage

// File: rtl/qws_left_path.sv
module qws_left_path #(
    parameter int DIGITS  = 4,
    parameter int DIGIT_W = 2,
    localparam int LANES  = DIGITS - 1,
    localparam int AW     = $clog2(DIGITS)
) (
    input  logic [DIGITS-1:0][DIGIT_W-1:0] word_i,
    input  logic [LANES-1:0][DIGIT_W-1:0]  lane_in_i,
    input  logic [AW-1:0]                  dist_i,
    output logic [DIGITS-1:0][DIGIT_W-1:0] word_o,
    output logic [LANES-1:0][DIGIT_W-1:0]  lane_out_o
);
    for (genvar i = 0; i < DIGITS; i++) begin : g_word
        logic [DIGITS-1:0][DIGIT_W-1:0] cand;
        for (genvar k = 0; k < DIGITS; k++) begin : g_dist
            if (i < k) begin : g_fill
                assign cand[k] = lane_in_i[i];
            end else begin : g_move
                assign cand[k] = word_i[i-k];
            end
        end
        assign word_o[i] = cand[dist_i];
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [DIGITS-1:0][DIGIT_W-1:0] cand;
        for (genvar k = 0; k < DIGITS; k++) begin : g_dist
            if (j < k) begin : g_spill
                assign cand[k] = word_i[DIGITS-k+j];
            end else begin : g_zero
                assign cand[k] = '0;
            end
        end
        assign lane_out_o[j] = cand[dist_i];
    end
endmodule

// File: rtl/qws_right_path.sv
module qws_right_path #(
    parameter int DIGITS  = 4,
    parameter int DIGIT_W = 2,
    localparam int LANES  = DIGITS - 1,
    localparam int AW     = $clog2(DIGITS)
) (
    input  logic [DIGITS-1:0][DIGIT_W-1:0] word_i,
    input  logic [LANES-1:0][DIGIT_W-1:0]  lane_in_i,
    input  logic [AW-1:0]                  dist_i,
    output logic [DIGITS-1:0][DIGIT_W-1:0] word_o,
    output logic [LANES-1:0][DIGIT_W-1:0]  lane_out_o
);
    for (genvar i = 0; i < DIGITS; i++) begin : g_word
        logic [DIGITS-1:0][DIGIT_W-1:0] cand;
        for (genvar k = 0; k < DIGITS; k++) begin : g_dist
            if (i >= DIGITS - k) begin : g_fill
                assign cand[k] = lane_in_i[i-1];
            end else begin : g_move
                assign cand[k] = word_i[i+k];
            end
        end
        assign word_o[i] = cand[dist_i];
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [DIGITS-1:0][DIGIT_W-1:0] cand;
        for (genvar k = 0; k < DIGITS; k++) begin : g_dist
            if (j >= LANES - k) begin : g_spill
                assign cand[k] = word_i[j-(LANES-k)];
            end else begin : g_zero
                assign cand[k] = '0;
            end
        end
        assign lane_out_o[j] = cand[dist_i];
    end
endmodule

// File: rtl/qws_rotate_path.sv
module qws_rotate_path #(
    parameter int DIGITS   = 4,
    parameter int DIGIT_W  = 2,
    parameter bit TOWARD_LSB = 1'b1,
    localparam int AW      = $clog2(DIGITS)
) (
    input  logic [DIGITS-1:0][DIGIT_W-1:0] word_i,
    input  logic [AW-1:0]                  dist_i,
    output logic [DIGITS-1:0][DIGIT_W-1:0] word_o
);
    for (genvar i = 0; i < DIGITS; i++) begin : g_word
        logic [DIGITS-1:0][DIGIT_W-1:0] cand;
        for (genvar k = 0; k < DIGITS; k++) begin : g_dist
            if (TOWARD_LSB) begin : g_ror
                assign cand[k] = word_i[(i+k) % DIGITS];
            end else begin : g_rol
                assign cand[k] = word_i[(i-k+DIGITS) % DIGITS];
            end
        end
        assign word_o[i] = cand[dist_i];
    end
endmodule

// File: rtl/quad_word_shifter.sv
module quad_word_shifter
    import qws_pkg::*;
#(
    parameter int DIGITS  = 4,
    parameter int DIGIT_W = 2,
    localparam int LANES  = DIGITS - 1,
    localparam int AW     = $clog2(DIGITS),
    localparam int WW     = DIGITS * DIGIT_W,
    localparam int LW     = LANES * DIGIT_W
) (
    input  logic [WW-1:0] word_i,
    input  logic [AW-1:0] dist_i,
    input  logic [1:0]    mode_i,
    input  logic [LW-1:0] lane_in_i,
    output logic [WW-1:0] word_o,
    output logic [LW-1:0] lane_out_o
);
    typedef struct packed {
        logic [WW-1:0] word;
        logic [LW-1:0] lanes;
    } qws_res_t;

    logic [WW-1:0] left_word, right_word, ror_word, rol_word;
    logic [LW-1:0] left_lanes, right_lanes;
    qws_res_t      res_d;

    qws_left_path #(.DIGITS(DIGITS), .DIGIT_W(DIGIT_W)) u_left (
        .word_i    (word_i),
        .lane_in_i (lane_in_i),
        .dist_i    (dist_i),
        .word_o    (left_word),
        .lane_out_o(left_lanes)
    );

    qws_right_path #(.DIGITS(DIGITS), .DIGIT_W(DIGIT_W)) u_right (
        .word_i    (word_i),
        .lane_in_i (lane_in_i),
        .dist_i    (dist_i),
        .word_o    (right_word),
        .lane_out_o(right_lanes)
    );

    qws_rotate_path #(.DIGITS(DIGITS), .DIGIT_W(DIGIT_W), .TOWARD_LSB(1'b1)) u_ror (
        .word_i(word_i),
        .dist_i(dist_i),
        .word_o(ror_word)
    );

    qws_rotate_path #(.DIGITS(DIGITS), .DIGIT_W(DIGIT_W), .TOWARD_LSB(1'b0)) u_rol (
        .word_i(word_i),
        .dist_i(dist_i),
        .word_o(rol_word)
    );

    // Output stage: pick one path per mode; rotates never drive the lanes.
    always_comb begin
        res_d = '0;
        unique case (qws_mode_e'(mode_i))
            MODE_LEFT: begin
                res_d.word  = left_word;
                res_d.lanes = left_lanes;
            end
            MODE_RIGHT: begin
                res_d.word  = right_word;
                res_d.lanes = right_lanes;
            end
            MODE_ROTR: res_d.word = ror_word;
            MODE_ROTL: res_d.word = rol_word;
            default:   res_d = '0;
        endcase
    end

    assign word_o     = res_d.word;
    assign lane_out_o = res_d.lanes;
endmodule

// File: rtl/qws_checker.sv
module qws_checker #(
    parameter int DIGITS  = 4,
    parameter int DIGIT_W = 2,
    localparam int LANES  = DIGITS - 1,
    localparam int AW     = $clog2(DIGITS),
    localparam int WW     = DIGITS * DIGIT_W,
    localparam int LW     = LANES * DIGIT_W
) (
    input logic [WW-1:0] word_i,
    input logic [AW-1:0] dist_i,
    input logic [1:0]    mode_i,
    input logic [LW-1:0] lane_in_i,
    input logic [WW-1:0] word_o,
    input logic [LW-1:0] lane_out_o
);
    always_comb begin
        // R3: no distance, no spill
        if (mode_i == 2'b00 && dist_i == '0) begin
            assert_left_still_R3: assert (lane_out_o == '0 && word_o == word_i)
                else $error("R3 left shift by zero altered data");
        end
        // R1: a left shift with empty lanes keeps every set bit somewhere
        if (mode_i == 2'b00 && lane_in_i == '0) begin
            assert_left_conserve_R1: assert ($countones(word_o) + $countones(lane_out_o) == $countones(word_i))
                else $error("R1 left shift lost or invented bits");
        end
        // R4: same conservation for right shifts
        if (mode_i == 2'b01 && lane_in_i == '0) begin
            assert_right_conserve_R4: assert ($countones(word_o) + $countones(lane_out_o) == $countones(word_i))
                else $error("R4 right shift lost or invented bits");
        end
        // R7: rotates keep the lanes silent
        if (mode_i[1]) begin
            assert_rot_lanes_quiet_R7: assert (lane_out_o == '0)
                else $error("R7 rotate drove neighbour lanes");
        end
        // R6: rotation neither loses nor adds bits
        if (mode_i[1]) begin
            assert_rot_conserve_R6: assert ($countones(word_o) == $countones(word_i))
                else $error("R6 rotate changed bit population");
        end
    end
endmodule

bind quad_word_shifter qws_checker #(.DIGITS(DIGITS), .DIGIT_W(DIGIT_W)) u_qws_checker (
    .word_i    (word_i),
    .dist_i    (dist_i),
    .mode_i    (mode_i),
    .lane_in_i (lane_in_i),
    .word_o    (word_o),
    .lane_out_o(lane_out_o)
);

// File: tb/test_quad_word_shifter.sv
`timescale 1ns/1ps
module test_quad_word_shifter;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [7:0] word_i;
    logic [1:0] dist_i, mode_i;
    logic [5:0] lane_in_i;
    logic [7:0] word_o;
    logic [5:0] lane_out_o;

    quad_word_shifter i_quad_word_shifter (
        .word_i(word_i), .dist_i(dist_i), .mode_i(mode_i),
        .lane_in_i(lane_in_i), .word_o(word_o), .lane_out_o(lane_out_o)
    );

    // Cascaded pairs for R8
    logic [15:0] cw;
    logic [7:0]  cl_lo_w, cl_hi_w, cr_lo_w, cr_hi_w;
    logic [5:0]  cl_lo_l, cl_hi_l, cr_lo_l, cr_hi_l;

    quad_word_shifter i_cl_lo (.word_i(cw[7:0]),  .dist_i(dist_i), .mode_i(2'b00),
        .lane_in_i(6'd0),    .word_o(cl_lo_w), .lane_out_o(cl_lo_l));
    quad_word_shifter i_cl_hi (.word_i(cw[15:8]), .dist_i(dist_i), .mode_i(2'b00),
        .lane_in_i(cl_lo_l), .word_o(cl_hi_w), .lane_out_o(cl_hi_l));
    quad_word_shifter i_cr_hi (.word_i(cw[15:8]), .dist_i(dist_i), .mode_i(2'b01),
        .lane_in_i(6'd0),    .word_o(cr_hi_w), .lane_out_o(cr_hi_l));
    quad_word_shifter i_cr_lo (.word_i(cw[7:0]),  .dist_i(dist_i), .mode_i(2'b01),
        .lane_in_i(cr_hi_l), .word_o(cr_lo_w), .lane_out_o(cr_lo_l));

    function automatic int ref_word(int m, int w, int k, int li);
        case (m)
            0: return ((w << (2*k)) & 255) | (li & ((1 << (2*k)) - 1));
            1: return (w >> (2*k)) | (((li >> (2*(3-k))) << (2*(4-k))) & 255);
            2: return ((w | (w << 8)) >> (2*k)) & 255;
            default: return ((w << (2*k)) | (w >> (8 - 2*k))) & 255;
        endcase
    endfunction

    function automatic int ref_lanes(int m, int w, int k);
        case (m)
            0: return (w << (2*k)) >> 8;
            1: return (w & ((1 << (2*k)) - 1)) << (2*(3-k));
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic apply(int m, int w, int k, int li);
        @(posedge clk);
        mode_i = m[1:0]; word_i = w[7:0]; dist_i = k[1:0]; lane_in_i = li[5:0];
        @(negedge clk);
    endtask

    task automatic judge(int m, int w, int k, int li);
        string tw, tl;
        apply(m, w, k, li);
        case (m)
            0: begin tw = (li == 0) ? "R1 left word" : "R2 left fill";
                     tl = (k == 0) ? "R3 left lanes" : "R1 left lanes"; end
            1: begin tw = (li == 0) ? "R4 right word" : "R5 right fill";
                     tl = "R4 right lanes"; end
            default: begin tw = "R6 rotate word"; tl = "R7 rotate lanes"; end
        endcase
        check(tw, int'(word_o), ref_word(m, w, k, li));
        check(tl, int'(lane_out_o), ref_lanes(m, w, k));
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        word_i = '0; dist_i = '0; mode_i = '0; lane_in_i = '0; cw = '0;
        @(negedge clk);
        check("R3 idle word", int'(word_o), 0);
        check("R3 idle lanes", int'(lane_out_o), 0);

        // directed corners
        judge(0, 8'hFF, 0, 0);
        judge(0, 8'hFF, 3, 0);
        judge(0, 8'hE4, 3, 6'h3F);
        judge(1, 8'hFF, 3, 0);
        judge(1, 8'h1B, 2, 6'h2D);
        judge(2, 8'hE4, 1, 6'h3F);
        judge(3, 8'hE4, 3, 6'h15);

        // R7: lane inputs ignored in rotate
        for (int m = 2; m < 4; m++) begin
            for (int k = 0; k < 4; k++) begin
                int w;
                int a;
                w = $urandom & 255;
                apply(m, w, k, 0);
                a = int'(word_o);
                apply(m, w, k, 6'h3F);
                check("R7 lanes ignored", int'(word_o), a);
            end
        end

        // random sweep of every mode and distance
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 4; k++) begin
                for (int n = 0; n < 40; n++) begin
                    int w;
                    int li;
                    w = $urandom & 255;
                    li = (n % 2 == 0) ? 0 : ($urandom & 63);
                    judge(m, w, k, li);
                end
            end
        end

        // R8 cascaded pairs
        for (int k = 0; k < 4; k++) begin
            for (int n = 0; n < 20; n++) begin
                int w16;
                w16 = (n == 0) ? 16'hFFFF : ($urandom & 16'hFFFF);
                @(posedge clk);
                cw = w16[15:0]; dist_i = k[1:0];
                @(negedge clk);
                check("R8 cascade left", int'({cl_hi_w, cl_lo_w}), (w16 << (2*k)) & 16'hFFFF);
                check("R8 cascade right", int'({cr_hi_w, cr_lo_w}), w16 >> (2*k));
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule